// File: doc/BRIEF.md
# SPI Master with Inter-Byte Decode Gap

This block is an SPI master sequencer for slaves that need a fixed decode time after each byte. The host starts a frame with one pulse that carries a write count and a read count. The master lowers chip select and shifts out the write bytes, which it takes from a valid/ready stream. It then clocks the read bytes while driving 0x00 and returns each captured byte with a one-cycle strobe. At the end it holds chip select low for the decode time, raises it and pulses done.

Timing is set by parameters in system clocks. `HALF_DIV` is the length of one SCLK half period. `SLAVE_PERIOD_CLKS` is one period of the slave's own clock, and `DECODE_PERIODS` is the number of those periods the slave needs. The required time is REQ = DECODE_PERIODS * SLAVE_PERIOD_CLKS. One byte takes BYTE = 16 * HALF_DIV clocks. The extra gap between bytes is GAP = max(0, REQ - BYTE). When one byte already lasts longer than the decode time, no gap is added.

Top module: `spi_gap_master`

## Requirements
- R1: While synchronous reset (`rst_n` low) is applied, and after it, the outputs are spi_cs_n = 1, spi_sclk = 0, spi_mosi = 0, tx_ready = 0, rx_valid = 0 and done = 0, and the master waits for a start.
- R2: Transfers use SPI mode 1 with the most significant bit first. SCLK idles low and each half period lasts HALF_DIV clocks. A new MOSI bit is presented on each rising SCLK edge and never changes on a falling edge, and MISO is sampled on each falling edge.
- R3: spi_cs_n falls in the clock after the accepted start and stays low until the frame ends. SCLK is high only while spi_cs_n is low.
- R4: When GAP > 0, each byte starts exactly BYTE + GAP + 1 clocks after the previous byte starts, with SCLK low in between. This is never less than REQ clocks.
- R5: After the last SCLK period, spi_cs_n stays low for exactly REQ clocks. It then rises in the same cycle as a single-cycle done pulse.
- R6: When BYTE >= REQ, GAP is zero and each byte starts BYTE + 1 clocks after the previous one.
- R7: A write byte is fetched through tx_valid/tx_ready. tx_ready is high only while the master is waiting for a write byte, with spi_cs_n low and SCLK low. The byte is transferred in the cycle where both are high.
- R8: During read bytes spi_mosi is 0. rx_valid is high for one clock, one clock after each read byte's last SCLK period. In that clock rx_data holds the eight sampled MISO bits, with the first sampled bit in bit 7.
- R9: A start is ignored while a frame is in progress, and when both counts are zero.
- R10: Within a frame, all write bytes are sent first, in the order they are accepted, and the read bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| wr_count | input | CNT_W | Number of write bytes, sampled with start |
| rd_count | input | CNT_W | Number of read bytes, sampled with start |
| tx_valid | input | 1 | Host offers a write byte |
| tx_data | input | 8 | Write byte |
| tx_ready | output | 1 | Master accepts a write byte this cycle |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse when chip select is released |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The bench runs two configurations, one where the gap is needed and one where the byte time already covers the decode time. A design that added or dropped the gap in the wrong case would start its bytes on the wrong clock.

It also probes these corner cases:
- Read-only frames, write-only frames and mixed frames. A design that mixed up the order of the byte kinds would put data on MOSI during read bytes.
- The tail hold before chip select rises. A master that skipped the hold when the gap was zero would release the slave before decode completes.
- A start during a frame, and a start with both counts zero. A design that accepted either would restart or lower chip select for no reason.

// File: rtl/spi_gap_pkg.sv
// Package: shared types and timing helpers of the decode-gap SPI master.
// Assumes all timing inputs are given in system clock cycles.
package spi_gap_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_GAP,
        SQ_TAIL
    } sq_state_t;

    // Extra idle clocks between bytes: required time minus byte time, floored at zero.
    function automatic int gap_clks(input int req_clks, input int byte_clks);
        return (req_clks > byte_clks) ? (req_clks - byte_clks) : 0;
    endfunction

endpackage

// File: rtl/spi_gap_timer.sv
// Module: down-counting gap timer.
// A load starts a window of load_val clocks (load_val >= 1).
// expire is high in the last clock of that window.
module spi_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic         running;
    logic [W-1:0] cnt;

    // Count down the loaded window and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= load_val - W'(1);
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end

    assign expire = running && (cnt == '0);
endmodule

// File: rtl/spi_gap_shifter.sv
// Module: mode 1 byte shifter with built-in SCLK divider.
// On load it raises SCLK and presents bit 7. It runs 16 half periods of HALF_DIV clocks each.
// MISO is sampled on every falling edge. The next MOSI bit is driven on every rising edge.
// last is high in the final clock of the byte. MOSI returns to 0 after the byte.
module spi_gap_shifter #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       last,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

    logic             busy;
    logic [7:0]       shreg;
    logic [3:0]       half;
    logic [DIV_W-1:0] dcnt;
    logic             half_end;

    assign half_end = busy && (dcnt == DIV_END);

    // Sequence the 16 half periods: sample on falls, present the next bit on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sclk  <= 1'b0;
            mosi  <= 1'b0;
            shreg <= '0;
            half  <= '0;
            dcnt  <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            sclk  <= 1'b1;
            mosi  <= load_byte[7];
            shreg <= load_byte;
            half  <= '0;
            dcnt  <= '0;
        end else if (half_end) begin
            dcnt <= '0;
            if (!half[0]) begin
                sclk  <= 1'b0;
                shreg <= {shreg[6:0], miso};
                half  <= half + 4'd1;
            end else if (half == 4'd15) begin
                busy <= 1'b0;
                mosi <= 1'b0;
            end else begin
                sclk <= 1'b1;
                mosi <= shreg[7];
                half <= half + 4'd1;
            end
        end else if (busy) begin
            dcnt <= dcnt + DIV_W'(1);
        end
    end

    assign last    = half_end && (half == 4'd15);
    assign rx_byte = shreg;
endmodule

// File: rtl/spi_gap_master.sv
// Module: SPI master frame sequencer with inter-byte decode gap (top).
// Sends wr_count bytes from the host stream and then clocks rd_count bytes while driving 0x00.
// Between bytes it waits GAP_CLKS clocks, and before releasing chip select it waits REQ_CLKS clocks.
// Assumes REQ_CLKS >= 1 and that the host holds the counts with the start pulse.
module spi_gap_master
    import spi_gap_pkg::*;
#(
    parameter int HALF_DIV          = 4,
    parameter int SLAVE_PERIOD_CLKS = 25,
    parameter int DECODE_PERIODS    = 4,
    parameter int CNT_W             = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [CNT_W-1:0] rd_count,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int BYTE_CLKS = 16 * HALF_DIV;
    localparam int REQ_CLKS  = DECODE_PERIODS * SLAVE_PERIOD_CLKS;
    localparam int GAP_CLKS  = gap_clks(REQ_CLKS, BYTE_CLKS);
    localparam int TMR_W     = $clog2(REQ_CLKS + 1);

    sq_state_t        state;
    logic [CNT_W-1:0] wr_left;
    logic [CNT_W-1:0] rd_left;
    logic             cur_rd;
    logic             eng_load;
    logic [7:0]       eng_byte;
    logic             eng_last;
    logic [7:0]       eng_rx;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             gap_used;
    logic [TMR_W-1:0] gap_val;
    logic             more_bytes;
    logic             want_wr;

    // Pick the gap variant: a timed gap, or going straight to the next fetch.
    generate
        if (GAP_CLKS > 0) begin : g_gap
            assign gap_used = 1'b1;
            assign gap_val  = TMR_W'(GAP_CLKS);
        end else begin : g_nogap
            assign gap_used = 1'b0;
            assign gap_val  = '0;
        end
    endgenerate

    assign want_wr    = (wr_left != '0);
    assign more_bytes = want_wr || (rd_left != '0);
    assign tx_ready   = (state == SQ_LOAD) && want_wr;

    // Decide the byte launch and the timer load for the current state.
    always_comb begin
        eng_load = 1'b0;
        eng_byte = 8'h00;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(REQ_CLKS);
        if ((state == SQ_LOAD) && (!want_wr || tx_valid)) begin
            eng_load = 1'b1;
            eng_byte = want_wr ? tx_data : 8'h00;
        end
        if ((state == SQ_SHIFT) && eng_last) begin
            if (!more_bytes) begin
                tmr_load = 1'b1;
            end else if (gap_used) begin
                tmr_load = 1'b1;
                tmr_val  = gap_val;
            end
        end
    end

    // Frame sequencer: chip select, byte counts, strobes and state moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            spi_cs_n <= 1'b1;
            wr_left  <= '0;
            rd_left  <= '0;
            cur_rd   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            done     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            done     <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start && ((wr_count != '0) || (rd_count != '0))) begin
                        spi_cs_n <= 1'b0;
                        wr_left  <= wr_count;
                        rd_left  <= rd_count;
                        state    <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    if (eng_load) begin
                        cur_rd <= !want_wr;
                        if (want_wr) begin
                            wr_left <= wr_left - CNT_W'(1);
                        end else begin
                            rd_left <= rd_left - CNT_W'(1);
                        end
                        state <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (eng_last) begin
                        if (cur_rd) begin
                            rx_valid <= 1'b1;
                            rx_data  <= eng_rx;
                        end
                        if (!more_bytes) begin
                            state <= SQ_TAIL;
                        end else if (gap_used) begin
                            state <= SQ_GAP;
                        end else begin
                            state <= SQ_LOAD;
                        end
                    end
                end
                SQ_GAP: begin
                    if (tmr_expire) begin
                        state <= SQ_LOAD;
                    end
                end
                SQ_TAIL: begin
                    if (tmr_expire) begin
                        spi_cs_n <= 1'b1;
                        done     <= 1'b1;
                        state    <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    spi_gap_shifter #(.HALF_DIV(HALF_DIV)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (eng_load),
        .load_byte (eng_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .last      (eng_last),
        .rx_byte   (eng_rx)
    );

    spi_gap_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );
endmodule

// File: rtl/spi_gap_master_sva.sv
// Module: assertion checker for spi_gap_master, attached by bind.
// It watches only the ports. Counters measure spacing between byte starts and from the last SCLK fall to release.
module spi_gap_master_sva #(
    parameter int SLAVE_PERIOD_CLKS = 25,
    parameter int DECODE_PERIODS    = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tx_ready,
    input logic rx_valid,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    localparam int REQ_CLKS = DECODE_PERIODS * SLAVE_PERIOD_CLKS;

    logic        sclk_q;
    logic [2:0]  rise_idx;
    logic        have_prev;
    logic [15:0] since_start;
    logic [15:0] since_fall;

    // Track SCLK history, the byte boundaries and the elapsed clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q      <= 1'b0;
            rise_idx    <= '0;
            have_prev   <= 1'b0;
            since_start <= '0;
            since_fall  <= '0;
        end else begin
            sclk_q <= spi_sclk;
            if (since_start != 16'hFFFF) since_start <= since_start + 16'd1;
            if (since_fall != 16'hFFFF) since_fall <= since_fall + 16'd1;
            if (sclk_q && !spi_sclk) since_fall <= 16'd1;
            if (spi_cs_n) begin
                rise_idx  <= '0;
                have_prev <= 1'b0;
            end else if (spi_sclk && !sclk_q) begin
                rise_idx <= rise_idx + 3'd1;
                if (rise_idx == 3'd0) begin
                    since_start <= 16'd1;
                    have_prev   <= 1'b1;
                end
            end
        end
    end

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n); // R3
    AST_MOSI_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sclk) |-> $stable(spi_mosi)); // R2
    AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_sclk) && (rise_idx == 3'd0) && have_prev) |-> (since_start >= 16'(REQ_CLKS))); // R4
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (since_fall >= 16'(REQ_CLKS))); // R5
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!spi_cs_n && !spi_sclk)); // R7
    AST_RXV_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !spi_cs_n); // R8
endmodule

bind spi_gap_master spi_gap_master_sva #(
    .SLAVE_PERIOD_CLKS (SLAVE_PERIOD_CLKS),
    .DECODE_PERIODS    (DECODE_PERIODS)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi)
);

// File: tb/tb_spi_lane.sv
`timescale 1ns/1ps
// Bench lane: one master configuration, a behavioural mode 1 slave and a cycle-by-cycle timeline model.
module tb_spi_lane #(
    parameter int HALF_DIV          = 4,
    parameter int SLAVE_PERIOD_CLKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    output int   checks,
    output int   errors,
    output logic finished
);
    localparam int BYTE = 16 * HALF_DIV;
    localparam int REQ  = 4 * SLAVE_PERIOD_CLKS;
    localparam int GAP  = (REQ > BYTE) ? REQ - BYTE : 0;
    localparam int STEP = BYTE + GAP + 1;

    logic       start;
    logic [3:0] wr_count, rd_count;
    logic       tx_valid, tx_ready, rx_valid, done;
    logic [7:0] tx_data, rx_data;
    logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int         cyc;
    int         p0;
    int         fw, fr;
    logic [7:0] txb [16];
    logic [7:0] seed;
    string      ctx;
    string      gtag;
    int         hs_idx;
    logic       pending;
    int         sb, sk;

    spi_gap_master #(
        .HALF_DIV(HALF_DIV), .SLAVE_PERIOD_CLKS(SLAVE_PERIOD_CLKS), .DECODE_PERIODS(4), .CNT_W(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_count(wr_count), .rd_count(rd_count),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] reply(input int k);
        return 8'hC3 ^ seed ^ 8'(k * 29);
    endfunction

    assign tx_valid = (p0 >= 0) && (hs_idx < fw);
    assign tx_data  = (hs_idx < 16) ? txb[hs_idx] : 8'h00;

    initial begin
        cyc = 0;
        p0 = -1;
        fw = 0;
        fr = 0;
        seed = 8'h00;
        ctx = "";
        gtag = (GAP > 0) ? "R4" : "R6";
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Slave: present the next reply bit on each rising SCLK edge.
    always @(negedge spi_cs_n) begin
        sb = 0;
        sk = 0;
    end
    always @(posedge spi_sclk) begin
        spi_miso <= reply(sk)[7 - sb];
        sb = sb + 1;
        if (sb == 8) begin
            sb = 0;
            sk = sk + 1;
        end
    end

    task automatic expect_at(input int d, output logic cs, output logic sc, output logic mo,
                             output logic rdy, output logic rv, output logic dn, output logic [7:0] rd);
        int n, e, k, r, j;
        cs = 1'b1; sc = 1'b0; mo = 1'b0; rdy = 1'b0; rv = 1'b0; dn = 1'b0; rd = 8'h00;
        if (p0 < 0 || d < 0) return;
        n = fw + fr;
        e = 1 + (n - 1) * STEP + BYTE;
        if (d > e + REQ) return;
        if (d == e + REQ) begin
            dn = 1'b1;
            return;
        end
        cs = 1'b0;
        if (d >= e) begin
            if (d == e && fr > 0) begin
                rv = 1'b1;
                rd = reply(n - 1);
            end
            return;
        end
        if (d == 0) begin
            rdy = (fw > 0);
            return;
        end
        k = (d - 1) / STEP;
        r = (d - 1) % STEP;
        if (r < BYTE) begin
            j  = r;
            sc = ((j / HALF_DIV) % 2) == 0;
            mo = (k < fw) ? txb[k][7 - j / (2 * HALF_DIV)] : 1'b0;
        end else begin
            if (r == BYTE && k >= fw) begin
                rv = 1'b1;
                rd = reply(k);
            end
            if (r == STEP - 1) rdy = (k + 1) < fw;
        end
    endtask

    // Compare every clock against the timeline, then advance the host byte stream.
    always @(negedge clk) begin
        logic ecs, esc, emo, erd, erv, edn;
        logic [7:0] erx;
        int d;
        if (!rst_n) begin
            if (cyc >= 1) begin
                checks = checks + 1;
                if (spi_cs_n !== 1'b1 || spi_sclk !== 1'b0 || spi_mosi !== 1'b0 || done !== 1'b0
                    || tx_ready !== 1'b0 || rx_valid !== 1'b0) begin
                    errors = errors + 1;
                    $display("FAIL R1 reset state act cs_n=%b sclk=%b mosi=%b done=%b exp 1 0 0 0",
                             spi_cs_n, spi_sclk, spi_mosi, done);
                end
            end
        end else begin
            d = cyc - p0;
            expect_at(d, ecs, esc, emo, erd, erv, edn, erx);
            checks = checks + 1;
            if (spi_cs_n !== ecs) begin
                errors = errors + 1;
                $display("FAIL R3/R5 %s cyc %0d cs_n act %b exp %b", ctx, d, spi_cs_n, ecs);
            end
            if (spi_sclk !== esc) begin
                errors = errors + 1;
                $display("FAIL R2 %s %s cyc %0d sclk act %b exp %b", gtag, ctx, d, spi_sclk, esc);
            end
            if (spi_mosi !== emo) begin
                errors = errors + 1;
                $display("FAIL R2 R8 R10 %s cyc %0d mosi act %b exp %b", ctx, d, spi_mosi, emo);
            end
            if (tx_ready !== erd) begin
                errors = errors + 1;
                $display("FAIL R7 %s cyc %0d tx_ready act %b exp %b", ctx, d, tx_ready, erd);
            end
            if (rx_valid !== erv || (erv && rx_data !== erx)) begin
                errors = errors + 1;
                $display("FAIL R8 %s cyc %0d rx act %b/%h exp %b/%h", ctx, d, rx_valid, rx_data, erv, erx);
            end
            if (done !== edn) begin
                errors = errors + 1;
                $display("FAIL R5 %s cyc %0d done act %b exp %b", ctx, d, done, edn);
            end
            if (d <= 0) hs_idx = 0;
            else if (pending) hs_idx = hs_idx + 1;
            pending = (d >= 0) && tx_ready && (hs_idx < fw);
        end
    end

    task automatic run_frame(input int w, input int r, input logic [7:0] s, input int poke, input string c);
        int e;
        @(negedge clk);
        ctx  = c;
        seed = s;
        for (int i = 0; i < 16; i++) txb[i] = 8'h3C ^ s ^ 8'(i * 71);
        fw = w;
        fr = r;
        p0 = cyc + 1;
        start = 1'b1;
        wr_count = 4'(w);
        rd_count = 4'(r);
        @(negedge clk);
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            start = 1'b1;
            wr_count = 4'd2;
            rd_count = 4'd2;
            @(negedge clk);
            start = 1'b0;
        end
        e = 1 + (w + r - 1) * STEP + BYTE;
        while (cyc <= p0 + e + REQ + 2) @(negedge clk);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        finished = 1'b0;
        start = 1'b0;
        wr_count = '0;
        rd_count = '0;
        hs_idx = 0;
        pending = 1'b0;
        spi_miso = 1'b0;
        sb = 0;
        sk = 0;
        wait (rst_n === 1'b1);
        repeat (3) @(negedge clk);
        run_frame(2, 0, 8'h00, 0, "write-only");
        run_frame(1, 2, 8'h5A, 0, "R10 mixed");
        run_frame(0, 3, 8'hA7, 0, "read-only");
        run_frame(3, 1, 8'h19, 40, "R9 start while busy");
        @(negedge clk);
        ctx = "R9 zero counts";
        start = 1'b1;
        wr_count = '0;
        rd_count = '0;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        run_frame(1, 0, 8'hFF, 0, "single byte");
        repeat (5) @(negedge clk);
        finished = 1'b1;
    end
endmodule

// File: tb/tb_spi_gap_master.sv
`timescale 1ns/1ps
// Top bench: runs a lane that needs the gap and a lane whose byte time already covers the decode time.
module tb_spi_gap_master;
    logic clk;
    logic rst_n;
    int   ca, ea, cb, eb;
    logic fa, fb;
    int   wd;
    int   total_c, total_e;

    tb_spi_lane #(.HALF_DIV(4), .SLAVE_PERIOD_CLKS(25)) u_lane_gap (
        .clk(clk), .rst_n(rst_n), .checks(ca), .errors(ea), .finished(fa)
    );
    tb_spi_lane #(.HALF_DIV(8), .SLAVE_PERIOD_CLKS(25)) u_lane_nogap (
        .clk(clk), .rst_n(rst_n), .checks(cb), .errors(eb), .finished(fb)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        wd = 0;
        while (!(fa === 1'b1 && fb === 1'b1) && wd < 150000) begin
            @(negedge clk);
            wd = wd + 1;
        end
        total_c = ca + cb;
        total_e = ea + eb;
        if (wd >= 150000) begin
            total_c = total_c + 1;
            total_e = total_e + 1;
            $display("FAIL R5 watchdog act %0d cycles exp frames finished", wd);
        end
        $display("CHECKS %0d ERRORS %0d", total_c, total_e);
        $finish;
    end
endmodule